// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block owns the chip-select line of an SPI controller. When the shift engine asks for a transfer, the block asserts chip select. It then waits a programmed number of clock cycles before it lets the serial clock run. When the shift engine reports that the final bit is complete, the block stops the clock and keeps chip select asserted for a programmed hold time. It then keeps chip select released for a programmed gap before another transfer may begin. A start request that arrives during the hold or the gap is remembered and is served as soon as the gap runs out.

The three delays come from two configuration words. Each field holds the cycle count minus one, so every delay lasts at least one cycle. A layout input picks between byte-wide and halfword-wide setup and hold fields. Two mode inputs widen the block's use. A keep-asserted mode parks the block with chip select active after the last bit, so that the next transfer follows without a new setup. A per-byte mode passes chip select through a full hold, gap and setup cycle after every byte. A synchronous software reset returns the block to its idle state with chip select inactive.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After `rst_n` is released, and one cycle after `soft_rst` is sampled high in any state, the block is idle: `sck_en` is 0 and `cs_out` is at its inactive level.
- R2: The asserted level of `cs_out` equals `cs_active_high` (1 = active-high, 0 = active-low), and the inactive level is its inverse.
- R3: When `xfer_start` is sampled in idle, `cs_out` asserts in the next cycle and stays asserted with `sck_en` low for exactly setup+1 cycles, after which `sck_en` rises.
- R4: With `wide_layout` = 0, the setup field is `timing_cfg[31:24]` and the hold field is `timing_cfg[23:16]`. Bits [15:0] are ignored.
- R5: With `wide_layout` = 1, the setup field is `timing_cfg[31:16]` and the hold field is `timing_cfg[15:0]`.
- R6: `sck_en` is high only while chip select is asserted and the active phase runs. It stays high until `last_done` is sampled and is low in the following cycle.
- R7: After `last_done` ends the active phase (keep-asserted mode off), `cs_out` stays asserted with `sck_en` low for exactly hold+1 cycles.
- R8: After the hold, `cs_out` is inactive for at least `gap_cfg`+1 cycles. A start request sampled during the hold or the gap is deferred, and chip select reasserts right after the gap.
- R9: With `pause_mode` = 1, `last_done` leaves `cs_out` asserted with `sck_en` low for as long as the mode stays set. A start sampled then raises `sck_en` in the next cycle with no setup delay.
- R10: Clearing `pause_mode` while parked deasserts `cs_out` in the next cycle and returns to idle with no hold or gap. A start is then accepted at once.
- R11: With `toggle_mode` = 1, a `byte_done` pulse in the active phase (without `last_done`) runs hold, gap and setup on their own, then re-enters the active phase.
- R12: With `toggle_mode` = 0, `byte_done` has no effect: `cs_out` stays asserted and `sck_en` stays high.
- R13: A field value of zero gives a delay of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset to idle |
| wide_layout | input | 1 | 0: byte-wide setup/hold fields, 1: halfword-wide fields |
| timing_cfg | input | 32 | Setup and hold fields, each count minus one |
| gap_cfg | input | 8 | Idle gap between transfers, count minus one |
| cs_active_high | input | 1 | Chip-select polarity, 1 = active-high |
| pause_mode | input | 1 | Keep chip select asserted after the last bit |
| toggle_mode | input | 1 | Cycle chip select after every byte |
| xfer_start | input | 1 | Start request from the shift engine |
| byte_done | input | 1 | One byte shifted (pulse) |
| last_done | input | 1 | Final bit of the transfer shifted (pulse) |
| cs_out | output | 1 | Chip-select pin level |
| sck_en | output | 1 | Serial clock enable for the clock generator |

## Verification
The assertions assume that the configuration words and the polarity stay steady while a transfer is running. They also assume that `last_done` and `byte_done` arrive only while the serial clock is enabled. The bench changes configuration only when the block is idle, after the full gap has run out. It raises completion pulses only after it has seen `sck_en` high. Start requests are raised in idle, during the gap, or while parked, because those are the phases whose outcome the requirements define.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4,
        ST_PAUSE  = 3'd5
    } seq_state_e;

    function automatic logic cs_phase(input seq_state_e st);
        return (st == ST_SETUP) || (st == ST_ACTIVE) ||
               (st == ST_HOLD)  || (st == ST_PAUSE);
    endfunction

endpackage

// File: rtl/spi_cs_field_decode.sv
module spi_cs_field_decode #(
    parameter int CFG_W    = 32,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int GAP_W    = 8
) (
    input  logic              wide_layout,
    input  logic [CFG_W-1:0]  timing_cfg,
    input  logic [GAP_W-1:0]  gap_cfg,
    output logic [WIDE_W-1:0] setup_len,
    output logic [WIDE_W-1:0] hold_len,
    output logic [WIDE_W-1:0] gap_len
);
    localparam int NAR_SETUP_HI = CFG_W - 1;
    localparam int NAR_HOLD_HI  = CFG_W - NARROW_W - 1;
    localparam int WID_SETUP_HI = CFG_W - 1;
    localparam int WID_HOLD_HI  = WIDE_W - 1;

    always_comb begin
        if (wide_layout) begin
            setup_len = timing_cfg[WID_SETUP_HI -: WIDE_W];
            hold_len  = timing_cfg[WID_HOLD_HI  -: WIDE_W];
        end else begin
            setup_len = WIDE_W'(timing_cfg[NAR_SETUP_HI -: NARROW_W]);
            hold_len  = WIDE_W'(timing_cfg[NAR_HOLD_HI  -: NARROW_W]);
        end
        gap_len = WIDE_W'(gap_cfg);
    end
endmodule

// File: rtl/spi_cs_pad_drive.sv
module spi_cs_pad_drive (
    input  logic cs_assert,
    input  logic cs_active_high,
    output logic cs_out
);
    assign cs_out = cs_active_high ? cs_assert : ~cs_assert;
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer #(
    parameter int CFG_W    = 32,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int GAP_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wide_layout,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic [GAP_W-1:0] gap_cfg,
    input  logic             cs_active_high,
    input  logic             pause_mode,
    input  logic             toggle_mode,
    input  logic             xfer_start,
    input  logic             byte_done,
    input  logic             last_done,
    output logic             cs_out,
    output logic             sck_en
);
    import spi_cs_seq_pkg::*;

    localparam int CNT_W = WIDE_W;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } seq_t;

    logic [CNT_W-1:0] setup_len, hold_len, gap_len;
    seq_t             seq_d, seq_q;
    logic             cs_assert;

    spi_cs_field_decode #(
        .CFG_W(CFG_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .GAP_W(GAP_W)
    ) u_decode (
        .wide_layout(wide_layout),
        .timing_cfg (timing_cfg),
        .gap_cfg    (gap_cfg),
        .setup_len  (setup_len),
        .hold_len   (hold_len),
        .gap_len    (gap_len)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    seq_d.st  = ST_SETUP;
                    seq_d.cnt = setup_len;
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt == '0) seq_d.st  = ST_ACTIVE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            ST_ACTIVE: begin
                if (last_done) begin
                    if (pause_mode) begin
                        seq_d.st = ST_PAUSE;
                    end else begin
                        seq_d.st  = ST_HOLD;
                        seq_d.cnt = hold_len;
                    end
                end else if (toggle_mode && byte_done) begin
                    seq_d.st   = ST_HOLD;
                    seq_d.cnt  = hold_len;
                    seq_d.pend = 1'b1;
                end
            end
            ST_HOLD: begin
                if (xfer_start) seq_d.pend = 1'b1;
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_GAP;
                    seq_d.cnt = gap_len;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.pend || xfer_start) begin
                        seq_d.st   = ST_SETUP;
                        seq_d.cnt  = setup_len;
                        seq_d.pend = 1'b0;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                    if (xfer_start) seq_d.pend = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (!pause_mode)     seq_d.st = ST_IDLE;
                else if (xfer_start) seq_d.st = ST_ACTIVE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (soft_rst) seq_d = '{st: ST_IDLE, cnt: '0, pend: 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, cnt: '0, pend: 1'b0};
        else        seq_q <= seq_d;
    end

    assign cs_assert = cs_phase(seq_q.st);
    assign sck_en    = (seq_q.st == ST_ACTIVE);

    spi_cs_pad_drive u_pad (
        .cs_assert     (cs_assert),
        .cs_active_high(cs_active_high),
        .cs_out        (cs_out)
    );

    AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (seq_q.st == ST_IDLE) && !sck_en); // R1
    AST_SETUP_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (seq_q.st == ST_SETUP && seq_q.cnt != '0) |=> (seq_q.st == ST_SETUP)); // R3
    AST_HOLD_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (seq_q.st == ST_HOLD && seq_q.cnt != '0) |=> (seq_q.st == ST_HOLD)); // R7
    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en |-> (cs_out == cs_active_high)); // R6
    AST_GAP_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_GAP) |-> (cs_out != cs_active_high)); // R8
    AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (seq_q.st == ST_PAUSE && !pause_mode) |=> (seq_q.st == ST_IDLE)); // R10
endmodule

// File: tb/tb_spi_cs_sequencer.sv
module tb_spi_cs_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wide_layout = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic [7:0]  gap_cfg = '0;
    logic        cs_active_high = 1'b0;
    logic        pause_mode = 1'b0;
    logic        toggle_mode = 1'b0;
    logic        xfer_start = 1'b0;
    logic        byte_done = 1'b0;
    logic        last_done = 1'b0;
    logic        cs_out, sck_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_cs_sequencer dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wide_layout(wide_layout),
        .timing_cfg(timing_cfg), .gap_cfg(gap_cfg), .cs_active_high(cs_active_high),
        .pause_mode(pause_mode), .toggle_mode(toggle_mode), .xfer_start(xfer_start),
        .byte_done(byte_done), .last_done(last_done), .cs_out(cs_out), .sck_en(sck_en)
    );

    // {wide, timing_cfg, gap_cfg, polarity, setup cycles, hold cycles, gap cycles}
    localparam int VW = 1 + 32 + 8 + 1 + 17 + 17 + 9;
    localparam int NV = 6;
    localparam logic [VW-1:0] VECS [NV] = '{
        {1'b0, 8'd3,   8'd2,  16'hFFFF, 8'd4,   1'b0, 17'd4,   17'd3,  9'd5},
        {1'b0, 8'd0,   8'd0,  16'hABCD, 8'd0,   1'b1, 17'd1,   17'd1,  9'd1},
        {1'b1, 16'd5,  16'd7,           8'd2,   1'b1, 17'd6,   17'd8,  9'd3},
        {1'b1, 16'd0,  16'd1,           8'd255, 1'b0, 17'd1,   17'd2,  9'd256},
        {1'b0, 8'd9,   8'd0,  16'h1234, 8'd1,   1'b1, 17'd10,  17'd1,  9'd2},
        {1'b1, 16'd300, 16'd40,         8'd7,   1'b0, 17'd301, 17'd41, 9'd8}
    };

    function automatic bit cs_on();
        return cs_out == cs_active_high;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_xfer(input int gap_cycles);
        int n = 0;
        while (!sck_en && n < 70000) begin n++; @(negedge clk); end
        last_done = 1'b1;
        @(negedge clk);
        last_done = 1'b0;
        n = 0;
        while (cs_on() && n < 70000) begin n++; @(negedge clk); end
        repeat (gap_cycles) @(negedge clk);
    endtask

    task automatic run_vec(input logic [VW-1:0] v);
        int s_cnt = 0, h_cnt = 0, g_cnt = 0, exp_s, exp_h, exp_g;
        wide_layout    = v[84];
        timing_cfg     = v[83:52];
        gap_cfg        = v[51:44];
        cs_active_high = v[43];
        exp_s = int'(v[42:26]);
        exp_h = int'(v[25:9]);
        exp_g = int'(v[8:0]);
        @(negedge clk);
        chk(cs_out == ~cs_active_high && !sck_en, "R2 idle level", cs_out, ~cs_active_high);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        while (!sck_en && s_cnt < 70000) begin
            if (cs_on()) s_cnt++;
            @(negedge clk);
        end
        chk(s_cnt == exp_s, v[84] ? "R3 R5 setup" : "R3 R4 setup", s_cnt, exp_s);
        repeat (2) @(negedge clk);
        last_done = 1'b1;
        @(negedge clk);
        last_done = 1'b0;
        while (cs_on() && !sck_en && h_cnt < 70000) begin h_cnt++; @(negedge clk); end
        chk(h_cnt == exp_h, v[84] ? "R7 R5 hold" : "R7 R4 hold", h_cnt, exp_h);
        xfer_start = 1'b1;
        while (!cs_on() && g_cnt < 70000) begin g_cnt++; @(negedge clk); end
        xfer_start = 1'b0;
        chk(g_cnt == exp_g, "R8 gap with deferred start", g_cnt, exp_g);
        finish_xfer(exp_g);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, active-low polarity -> pin high
        chk(cs_out == 1'b1 && !sck_en, "R1 reset idle", {cs_out, sck_en}, 2);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // Directed tests use all-zero fields: setup, hold, gap all one cycle (R13)
        wide_layout = 1'b0; timing_cfg = '0; gap_cfg = '0; cs_active_high = 1'b1;
        @(negedge clk);
        cs_active_high = 1'b0;
        #1;
        chk(cs_out == 1'b1, "R2 polarity switch in idle", cs_out, 1);
        cs_active_high = 1'b1;
        @(negedge clk);

        // R6: clock stays on until last_done, off the cycle after
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        chk(cs_on() && !sck_en, "R13 setup one cycle", sck_en, 0);
        @(negedge clk);
        repeat (3) begin
            chk(sck_en && cs_on(), "R6 sck held", sck_en, 1);
            @(negedge clk);
        end
        // R12: byte_done ignored with toggle off
        byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
        chk(sck_en && cs_on(), "R12 byte_done ignored", sck_en, 1);
        last_done = 1'b1; @(negedge clk); last_done = 1'b0;
        chk(!sck_en && cs_on(), "R6 sck off after last", sck_en, 0);
        @(negedge clk);
        chk(!cs_on(), "R13 hold one cycle", cs_out, 0);
        @(negedge clk);

        // R11: per-byte chip-select cycling
        toggle_mode = 1'b1;
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        @(negedge clk);
        byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
        chk(cs_on() && !sck_en, "R11 hold after byte", sck_en, 0);
        @(negedge clk);
        chk(!cs_on(), "R11 gap after byte", cs_out, 0);
        @(negedge clk);
        chk(cs_on() && !sck_en, "R11 auto setup", cs_out, 1);
        @(negedge clk);
        chk(sck_en, "R11 back to active", sck_en, 1);
        toggle_mode = 1'b0;
        finish_xfer(1);

        // R9 / R10: keep-asserted mode
        pause_mode = 1'b1;
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        @(negedge clk);
        last_done = 1'b1; @(negedge clk); last_done = 1'b0;
        repeat (4) @(negedge clk);
        chk(cs_on() && !sck_en, "R9 parked asserted", cs_out, 1);
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        chk(sck_en, "R9 resume without setup", sck_en, 1);
        last_done = 1'b1; @(negedge clk); last_done = 1'b0;
        pause_mode = 1'b0; @(negedge clk);
        chk(!cs_on() && !sck_en, "R10 release to idle", cs_out, 0);
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        chk(cs_on(), "R10 start accepted at once", cs_out, 1);

        // R1: software reset in the middle of a transfer
        @(negedge clk);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk(!cs_on() && !sck_en, "R1 soft reset", cs_out, 0);
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
        chk(cs_on(), "R1 start after soft reset", cs_out, 1);
        finish_xfer(1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule